// File: doc/BRIEF.md
# Mode-Selectable Saturating Multiplier

This combinational block multiplies two N-bit operands and returns an N-bit result that is clamped whenever the true product does not fit in N bits. A single mode input chooses how the operand bits are read: when it is low both operands are unsigned, and when it is high both are two's complement. Both modes share one partial-product array and one overflow detector. The array builds only the N+1 lowest product bits. Partial products that use exactly one operand sign bit are inverted in signed mode, and a correction one is added at column N in that mode.

Overflow is found next to the array and does not wait for the high half of the product. A leading-bit recurrence runs over operand bits that have been folded against their own sign bit in signed mode. Two small residual terms, one for each mode, then fill in the combinations the shared recurrence leaves out. The top two built product bits settle the cases that remain. On overflow an N-bit word mux replaces the low product bits with the bound of the active range.

Top module: `satmul_dual`

## Requirements
- R1: With `twos_mode`=0 and A·B ≤ 2^N−1 (operands read as unsigned), `result` equals A·B and `ovf` is 0.
- R2: With `twos_mode`=0 and A·B ≥ 2^N, `ovf` is 1 and `result` is all ones. This includes the exact boundary A·B = 2^N.
- R3: With `twos_mode`=1 and −2^(N−1) ≤ A·B ≤ 2^(N−1)−1 (operands read as two's complement), `result` equals the low N bits of A·B and `ovf` is 0.
- R4: With `twos_mode`=1 and A·B ≥ 2^(N−1), `ovf` is 1 and `result` is 0 followed by N−1 ones (the most positive value).
- R5: With `twos_mode`=1 and A·B < −2^(N−1), `ovf` is 1 and `result` is 1 followed by N−1 zeros. A product of exactly −2^(N−1) is returned with `ovf`=0.
- R6: The same operand bit patterns give results that follow the mode. For example, all-ones times all-ones saturates to all ones with `twos_mode`=0, and gives 1 with no overflow when `twos_mode`=1.
- R7: If either operand is zero, `result` is 0 and `ovf` is 0 in both modes.
- R8: In both modes, `ovf` is 1 exactly when the full-width product lies outside the active mode's N-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| twos_mode | input | 1 | 0: unsigned, 1: two's complement |
| result | output | N | Product, or the range bound on overflow |
| ovf | output | 1 | Product lay outside the N-bit range |

## Verification
Two functions can act on the same inputs at once: the overflow detector can flag a case while the array's low bits would alone give a plausible value, and the signed clamp must choose its sign in the same evaluation. This is provoked at the edges of the range, where the recurrence, a residual term and the top product bits each decide alone. Examples are 2^N exactly in unsigned mode, 2^(N−1) and −2^(N−1) in signed mode, and operands that carry a sign bit with only one other bit set. Each such case is judged by comparing both `result` and `ovf` with a full-width product clamped to the range the mode selects. All operand pairs in both modes are compared this way.

// File: rtl/satmul_pkg.sv
package satmul_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_TWOS     = 1'b1
    } mul_mode_e;

    // two highest product bits the array builds: column N and column N-1
    typedef struct packed {
        logic col_n;
        logic col_n1;
    } top_bits_t;

    // what the clamp needs from the detector and the operand signs
    typedef struct packed {
        logic flag;
        logic neg;
    } clamp_ctl_t;

    // merge the shared flag with the residual belonging to the active mode
    function automatic logic merge_flag(input logic v_pre, input mul_mode_e m,
                                        input logic rt, input logic ru,
                                        input top_bits_t tb);
        logic tail;
        if (m == MODE_TWOS) tail = rt | (tb.col_n ^ tb.col_n1);
        else                tail = ru | tb.col_n;
        return v_pre | tail;
    endfunction

endpackage

// File: rtl/satmul_pparray.sv
module satmul_pparray #(
    parameter int N = 8
) (
    input  logic [N-1:0]         a,
    input  logic [N-1:0]         b,
    input  satmul_pkg::mul_mode_e mode,
    output logic [N:0]           p
);
    localparam int W = N + 1;

    logic tw;
    assign tw = (mode == satmul_pkg::MODE_TWOS);

    // sum only the partial products that land in columns 0..N
    always_comb begin
        logic [W-1:0] acc;
        logic         pb;
        acc = '0;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (r + c <= N) begin
                    pb  = (a[c] & b[r]) ^ (tw & ((r == N-1) != (c == N-1)));
                    acc = acc + (W'(pb) << (r + c));
                end
            end
        end
        acc = acc + (W'(tw) << N);
        p = acc;
    end

endmodule

// File: rtl/satmul_ovfdet.sv
module satmul_ovfdet #(
    parameter int N = 8
) (
    input  logic [N-1:1]          a_hi,
    input  logic [N-1:1]          b_hi,
    input  satmul_pkg::mul_mode_e mode,
    input  satmul_pkg::top_bits_t top,
    output logic                  ovf
);
    logic tw;
    logic [N-2:1] au;
    logic [N-2:1] bu;
    logic [N-1:3] o_run;
    logic [N-1:3] v_run;
    logic ru_pre;
    logic ru;
    logic rt;

    assign tw = (mode == satmul_pkg::MODE_TWOS);

    // fold magnitude bits against their sign bit in signed mode
    assign au = a_hi[N-2:1] ^ {(N-2){tw & a_hi[N-1]}};
    assign bu = b_hi[N-2:1] ^ {(N-2){tw & b_hi[N-1]}};

    // shared leading-bit recurrence
    assign o_run[3] = au[N-2];
    assign v_run[3] = au[N-2] & bu[2];

    generate
        for (genvar i = 3; i <= N-2; i++) begin : g_step
            assign o_run[i+1] = o_run[i] | au[N-i];
            assign v_run[i+1] = v_run[i] | (o_run[i+1] & bu[i]);
        end
    endgenerate

    // unsigned residual: terms that involve an operand MSB
    assign ru_pre = |b_hi[N-1:1];
    assign ru     = (b_hi[N-1] & (a_hi[1] | o_run[N-1])) | (a_hi[N-1] & ru_pre);

    // signed residual: anti-diagonal just above the shared region
    always_comb begin
        rt = 1'b0;
        for (int i = 1; i <= N-2; i++) rt = rt | (au[N-1-i] & bu[i]);
    end

    assign ovf = satmul_pkg::merge_flag(v_run[N-1], mode, rt, ru, top);

endmodule

// File: rtl/satmul_clamp.sv
module satmul_clamp #(
    parameter int N = 8
) (
    input  logic [N-1:0]           prod_lo,
    input  satmul_pkg::clamp_ctl_t ctl,
    input  satmul_pkg::mul_mode_e  mode,
    output logic [N-1:0]           res
);
    logic [N-1:0] bound;

    always_comb begin
        if (mode == satmul_pkg::MODE_UNSIGNED) bound = '1;
        else                                   bound = {ctl.neg, {(N-1){~ctl.neg}}};
        res = ctl.flag ? bound : prod_lo;
    end

endmodule

// File: rtl/satmul_dual.sv
module satmul_dual #(
    parameter int N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         twos_mode,
    output logic [N-1:0] result,
    output logic         ovf
);
    import satmul_pkg::*;

    mul_mode_e  mode;
    logic [N:0] prod;
    top_bits_t  top;
    clamp_ctl_t ctl;
    logic       flag;

    assign mode = mul_mode_e'(twos_mode);

    satmul_pparray #(.N(N)) u_arr (
        .a    (op_a),
        .b    (op_b),
        .mode (mode),
        .p    (prod)
    );

    assign top = '{col_n: prod[N], col_n1: prod[N-1]};

    satmul_ovfdet #(.N(N)) u_det (
        .a_hi (op_a[N-1:1]),
        .b_hi (op_b[N-1:1]),
        .mode (mode),
        .top  (top),
        .ovf  (flag)
    );

    assign ctl = '{flag: flag, neg: op_a[N-1] ^ op_b[N-1]};

    satmul_clamp #(.N(N)) u_clamp (
        .prod_lo (prod[N-1:0]),
        .ctl     (ctl),
        .mode    (mode),
        .res     (result)
    );

    assign ovf = flag;

endmodule

// File: rtl/satmul_dual_chk.sv
module satmul_dual_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         twos_mode,
    input logic [N-1:0] result,
    input logic         ovf
);
    logic s;
    assign s = op_a[N-1] ^ op_b[N-1];

    always_comb begin
        if (!$isunknown({op_a, op_b, twos_mode})) begin
            p_uns_all_ones_r2: assert (twos_mode || !ovf || result == '1)
                else $error("unsigned overflow not all ones");
            // also covers R4: positive bound when the signs agree
            p_twos_bound_r5: assert (!twos_mode || !ovf || result == {s, {(N-1){~s}}})
                else $error("signed clamp picked the wrong bound");
            p_zero_operand_r7: assert (!(op_a == '0 || op_b == '0) || (!ovf && result == '0))
                else $error("zero operand produced nonzero or flag");
            // R3 as well: unit multiplier is exact in both modes
            p_unit_identity_r1: assert (op_b != N'(1) || (!ovf && result == op_a))
                else $error("multiply by one not exact");
            p_small_no_flag_r8: assert (twos_mode || op_a[N-1:1] != '0 || !ovf)
                else $error("unsigned operand 0/1 flagged overflow");
        end
    end

endmodule

bind satmul_dual satmul_dual_chk #(.N(N)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .twos_mode (twos_mode),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/sim_satmul_dual.sv
module sim_satmul_dual;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         twos_mode = 1'b0;
    logic [N-1:0] result;
    logic         ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    satmul_dual #(.N(N)) u0 (
        .op_a      (op_a),
        .op_b      (op_b),
        .twos_mode (twos_mode),
        .result    (result),
        .ovf       (ovf)
    );

    // full-width product clamped to the range the mode selects
    function automatic void ref_calc(input logic [N-1:0] a, input logic [N-1:0] b,
                                     input logic t, output logic [N-1:0] r,
                                     output logic f);
        int pr;
        int lo;
        int hi;
        if (t) begin
            pr = int'($signed(a)) * int'($signed(b));
            lo = -(1 << (N-1));
            hi = (1 << (N-1)) - 1;
        end else begin
            pr = int'(a) * int'(b);
            lo = 0;
            hi = (1 << N) - 1;
        end
        if (pr > hi)      begin r = N'(hi); f = 1'b1; end
        else if (pr < lo) begin r = N'(lo); f = 1'b1; end
        else              begin r = N'(pr); f = 1'b0; end
    endfunction

    task automatic apply_and_check(input string tag, input logic [N-1:0] a,
                                   input logic [N-1:0] b, input logic t,
                                   input logic [N-1:0] exp_r, input logic exp_f);
        op_a = a; op_b = b; twos_mode = t;
        #1;
        n_chk++;
        if (result !== exp_r || ovf !== exp_f) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h t=%0d: got result=%h ovf=%0b, expected result=%h ovf=%0b",
                     tag, a, b, t, result, ovf, exp_r, exp_f);
        end
    endtask

    task automatic t_idle_state;
        // R7: quiet inputs give a zero result and no flag
        apply_and_check("R7 idle", '0, '0, 1'b0, '0, 1'b0);
        apply_and_check("R7 idle", '0, '0, 1'b1, '0, 1'b0);
    endtask

    task automatic t_corners;
        apply_and_check("R1 max fit",       8'h0F, 8'h11, 1'b0, 8'hFF, 1'b0);
        apply_and_check("R2 exact 2^N",     8'h10, 8'h10, 1'b0, 8'hFF, 1'b1);
        apply_and_check("R2 msb times two", 8'h80, 8'h02, 1'b0, 8'hFF, 1'b1);
        apply_and_check("R2 msbs only",     8'h80, 8'h80, 1'b0, 8'hFF, 1'b1);
        apply_and_check("R3 in range",      8'hFD, 8'h05, 1'b1, 8'hF1, 1'b0);
        apply_and_check("R4 exact 2^(N-1)", 8'h40, 8'h02, 1'b1, 8'h7F, 1'b1);
        apply_and_check("R4 min times -1",  8'h80, 8'hFF, 1'b1, 8'h7F, 1'b1);
        apply_and_check("R4 min squared",   8'h80, 8'h80, 1'b1, 8'h7F, 1'b1);
        apply_and_check("R5 exact min",     8'hC0, 8'h02, 1'b1, 8'h80, 1'b0);
        apply_and_check("R5 below min",     8'h7F, 8'h81, 1'b1, 8'h80, 1'b1);
        apply_and_check("R6 unsigned ones", 8'hFF, 8'hFF, 1'b0, 8'hFF, 1'b1);
        apply_and_check("R6 signed ones",   8'hFF, 8'hFF, 1'b1, 8'h01, 1'b0);
        apply_and_check("R7 zero a",        8'h00, 8'hA5, 1'b1, 8'h00, 1'b0);
        apply_and_check("R7 zero b",        8'hFF, 8'h00, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic t_sweep(input logic t);
        logic [N-1:0] er;
        logic         ef;
        for (int ia = 0; ia < (1 << N); ia++) begin
            for (int ib = 0; ib < (1 << N); ib++) begin
                ref_calc(N'(ia), N'(ib), t, er, ef);
                // R8 everywhere; R1/R2 in unsigned mode, R3/R4/R5 in signed mode
                apply_and_check(t ? "R8 R3 R4 R5 signed sweep" : "R8 R1 R2 unsigned sweep",
                                N'(ia), N'(ib), t, er, ef);
            end
        end
    endtask

    initial begin
        t_idle_state();
        t_corners();
        t_sweep(1'b0);
        t_sweep(1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule